// File: doc/BRIEF.md
# Hypercube Dimension-Order Wormhole Router

This block is the router of one node in a binary hypercube of `DIM` dimensions. It has one link port for each dimension and one local port that injects and ejects traffic. There are `DIM+1` ports in all. Every port carries a stream of flits with valid/ready flow control. Each flit has a head marker, a tail marker and a `DATA_W`-bit payload. A packet starts with a head flit, whose low `DIM` payload bits give the destination node. It ends with a tail flit. A packet of one flit has both markers set. Body flits carry only payload.

Each input has a small flit FIFO. When a head flit reaches the front of its FIFO, the router XORs the destination with its own node address `my_addr`. It picks the dimension of the lowest set bit of the result. A zero result means the packet has arrived, and it goes to the local port. The chosen output is then held by that input until the tail flit has left, so the flits of the packet follow the head in order. When the head cannot move, the whole packet waits where it is, in the FIFO and upstream. The packet is never stored whole. Heads from several inputs that compete for the same free output are served round-robin.

Port index `k < DIM` is the link along dimension `k`. Index `DIM` is the local port. Port `k` of a packed vector sits at bit `k`, and its payload sits at `[k*DATA_W +: DATA_W]`.

Top module: `hc_router`

## Requirements
- R1: After reset, all `out_valid` bits are 0 and all `in_ready` bits are 1.
- R2: A head flit whose destination (payload bits `[DIM-1:0]`) differs from `my_addr` leaves on dimension port `k`. Here `k` is the index of the least significant 1 bit of destination XOR `my_addr`.
- R3: A head flit whose destination equals `my_addr` leaves on the local port (index `DIM`).
- R4: Flit format. Head and tail are separate bits, and a one-flit packet has both set. Every flit of a packet leaves on the same output as its head, in the order it arrived, with the payload unchanged. The tail marker is on the last flit only.
- R5: Once a head has left an output, no flit of another packet appears on that output until that packet's tail has left. The first flit an idle output presents is always a head.
- R6: While `out_ready` of an output is low, its `out_valid`, head, tail and payload hold. The blocked packet stays in its input FIFO. That input accepts exactly `FIFO_DEPTH` flits and then drops `in_ready`.
- R7: Head flits from different inputs that wait for the same free output are granted round-robin. The search starts at the input after the last one granted there, beginning at input 0 after reset.
- R8: After a tail flit leaves, its output is free for the next packet, and every packet offered is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | DIM | Address of this node |
| in_valid | input | DIM+1 | Flit offered on each input |
| in_ready | output | DIM+1 | Input FIFO has room |
| in_head | input | DIM+1 | Offered flit starts a packet |
| in_tail | input | DIM+1 | Offered flit ends a packet |
| in_data | input | (DIM+1)*DATA_W | Offered payload, one slice per port |
| out_valid | output | DIM+1 | Flit presented on each output |
| out_ready | input | DIM+1 | Downstream accepts the flit |
| out_head | output | DIM+1 | Presented flit starts a packet |
| out_tail | output | DIM+1 | Presented flit ends a packet |
| out_data | output | (DIM+1)*DATA_W | Presented payload, one slice per port |

## Verification
The situation hardest to reach from the ports is a contested output with all competitors already queued. Every competing head must be waiting, and the output must be released between packets. Only then does the grant order show the round-robin pointer rather than arrival time. The bench gets there by holding every `out_ready` low while two inputs each load two packets for the same output. It then opens the output and compares the order of heads with the rotation that is expected. A second directed case holds one output stalled behind a long packet. This shows that the worm stops in place, with a full FIFO and a frozen head flit.

// File: rtl/hc_pkg.sv
package hc_pkg;

   // Ownership state of one output link
   typedef enum logic [0:0] {
      LINK_FREE = 1'b0,
      LINK_HELD = 1'b1
   } link_state_e;

   // Increment with wrap at n (n >= 1)
   function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/hc_flit_fifo.sv
module hc_flit_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_valid,
   input  logic [W-1:0] wr_data,
   output logic         wr_ready,
   output logic         rd_valid,
   output logic [W-1:0] rd_data,
   input  logic         rd_pop
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          push, pop;

   assign wr_ready = (cnt != CW'(DEPTH));
   assign rd_valid = (cnt != '0);
   assign rd_data  = mem[rd_ptr];
   assign push     = wr_valid && wr_ready;
   assign pop      = rd_pop && rd_valid;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= AW'(hc_pkg::wrap_inc(int'(wr_ptr), DEPTH));
         if (pop)  rd_ptr <= AW'(hc_pkg::wrap_inc(int'(rd_ptr), DEPTH));
         case ({push, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/hc_ecube_route.sv
module hc_ecube_route #(
   parameter int DIM = 3,
   parameter int PW  = 2
) (
   input  logic [DIM-1:0] dest,
   input  logic [DIM-1:0] self_addr,
   output logic [PW-1:0]  port
);
   logic [DIM-1:0] diff;
   assign diff = dest ^ self_addr;

   // Scan from the top so the lowest set bit wins; zero diff selects local
   always_comb begin
      port = PW'(DIM);
      for (int b = DIM - 1; b >= 0; b--) begin
         if (diff[b]) port = PW'(b);
      end
   end
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          take,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);
   logic [IW-1:0] ptr;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (!gnt_valid && req[idx]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else if (take && gnt_valid) ptr <= IW'(hc_pkg::wrap_inc(int'(gnt_idx), N));
   end
endmodule

// File: rtl/hc_router.sv
module hc_router #(
   parameter int DIM        = 3,
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DIM-1:0]            my_addr,
   input  logic [DIM:0]              in_valid,
   output logic [DIM:0]              in_ready,
   input  logic [DIM:0]              in_head,
   input  logic [DIM:0]              in_tail,
   input  logic [(DIM+1)*DATA_W-1:0] in_data,
   output logic [DIM:0]              out_valid,
   input  logic [DIM:0]              out_ready,
   output logic [DIM:0]              out_head,
   output logic [DIM:0]              out_tail,
   output logic [(DIM+1)*DATA_W-1:0] out_data
);
   import hc_pkg::*;

   localparam int P  = DIM + 1;
   localparam int PW = $clog2(P);
   localparam int FW = DATA_W + 2;

   // Elaboration-time parameter checks
   if (DIM < 1) begin : g_bad_dim
      $error("hc_router: DIM must be at least 1");
   end
   if (DATA_W < DIM) begin : g_bad_width
      $error("hc_router: DATA_W must hold a DIM-bit destination");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("hc_router: FIFO_DEPTH must be at least 2");
   end

   logic [P-1:0]      f_valid, f_head, f_tail, pop, busy_in, held;
   logic [DATA_W-1:0] f_data  [P];
   logic [PW-1:0]     route_w [P];
   logic [PW-1:0]     owner_w [P];
   logic [P-1:0]      req_m   [P];

   // Input side: flit FIFO and route computation per port
   for (genvar i = 0; i < P; i++) begin : g_in
      logic [FW-1:0] wr_flit, rd_flit;
      assign wr_flit = {in_head[i], in_tail[i], in_data[i*DATA_W +: DATA_W]};

      hc_flit_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_valid (in_valid[i]),
         .wr_data  (wr_flit),
         .wr_ready (in_ready[i]),
         .rd_valid (f_valid[i]),
         .rd_data  (rd_flit),
         .rd_pop   (pop[i])
      );

      assign f_head[i] = rd_flit[FW-1];
      assign f_tail[i] = rd_flit[FW-2];
      assign f_data[i] = rd_flit[DATA_W-1:0];

      hc_ecube_route #(.DIM(DIM), .PW(PW)) u_route (
         .dest      (f_data[i][DIM-1:0]),
         .self_addr (my_addr),
         .port      (route_w[i])
      );
   end

   // An input that already owns an output may not request another
   always_comb begin
      busy_in = '0;
      for (int o = 0; o < P; o++) begin
         for (int i = 0; i < P; i++) begin
            if (held[o] && owner_w[o] == PW'(i)) busy_in[i] = 1'b1;
         end
      end
   end

   always_comb begin
      for (int o = 0; o < P; o++) begin
         req_m[o] = '0;
         for (int i = 0; i < P; i++) begin
            req_m[o][i] = f_valid[i] && f_head[i] && !busy_in[i] &&
                          (route_w[i] == PW'(o));
         end
      end
   end

   // Output side: arbiter plus packet lock per port
   for (genvar o = 0; o < P; o++) begin : g_out
      link_state_e   lock_q;
      logic [PW-1:0] owner_q;
      logic          gnt_valid;
      logic [PW-1:0] gnt_idx;
      logic          take;

      assign take = (lock_q == LINK_FREE);

      hc_rr_arb #(.N(P), .IW(PW)) u_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_m[o]),
         .take      (take),
         .gnt_valid (gnt_valid),
         .gnt_idx   (gnt_idx)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lock_q  <= LINK_FREE;
            owner_q <= '0;
         end else if (lock_q == LINK_FREE) begin
            if (gnt_valid) begin
               lock_q  <= LINK_HELD;
               owner_q <= gnt_idx;
            end
         end else if (out_valid[o] && out_ready[o] && out_tail[o]) begin
            lock_q <= LINK_FREE;
         end
      end

      assign held[o]    = (lock_q == LINK_HELD);
      assign owner_w[o] = owner_q;
   end

   // Crossbar: each held output shows the front flit of its owner
   always_comb begin
      for (int o = 0; o < P; o++) begin
         out_valid[o]                     = held[o] && f_valid[owner_w[o]];
         out_head[o]                      = f_head[owner_w[o]];
         out_tail[o]                      = f_tail[owner_w[o]];
         out_data[o*DATA_W +: DATA_W]     = f_data[owner_w[o]];
      end
   end

   always_comb begin
      pop = '0;
      for (int o = 0; o < P; o++) begin
         for (int i = 0; i < P; i++) begin
            if (held[o] && owner_w[o] == PW'(i) && out_ready[o] && f_valid[i])
               pop[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/hc_router_chk.sv
module hc_router_chk #(
   parameter int DIM    = 3,
   parameter int DATA_W = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [DIM-1:0]            my_addr,
   input logic [DIM:0]              in_ready,
   input logic [DIM:0]              out_valid,
   input logic [DIM:0]              out_ready,
   input logic [DIM:0]              out_head,
   input logic [DIM:0]              out_tail,
   input logic [(DIM+1)*DATA_W-1:0] out_data
);
   localparam int P = DIM + 1;

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_valid == '0) && (in_ready == '1));

   for (genvar o = 0; o < P; o++) begin : g_o
      logic           open_q;
      logic [DIM-1:0] diff;
      assign diff = out_data[o*DATA_W +: DIM] ^ my_addr;

      always_ff @(posedge clk) begin
         if (!rst_n) open_q <= 1'b0;
         else if (out_valid[o] && out_ready[o]) begin
            if (out_tail[o])      open_q <= 1'b0;
            else if (out_head[o]) open_q <= 1'b1;
         end
      end

      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[o] && !out_ready[o] |=> out_valid[o] &&
            $stable(out_data[o*DATA_W +: DATA_W]) && $stable(out_head[o]) &&
            $stable(out_tail[o]));

      assert_no_interleave_R5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[o] && open_q |-> !out_head[o]);

      assert_head_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[o] && !open_q |-> out_head[o]);

      if (o == DIM) begin : g_local
         assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_head[o] |-> diff == '0);
      end else begin : g_dim
         localparam logic [DIM-1:0] LOW = DIM'((1 << o) - 1);
         assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_head[o] |-> diff[o] && ((diff & LOW) == '0));
      end
   end
endmodule

bind hc_router hc_router_chk #(.DIM(DIM), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .my_addr   (my_addr),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_head  (out_head),
   .out_tail  (out_tail),
   .out_data  (out_data)
);

// File: tb/hc_router_tb.sv
`timescale 1ns/1ps
module hc_router_tb_top;
   localparam int DIM = 3;
   localparam int DW  = 8;
   localparam int FD  = 4;
   localparam int P   = DIM + 1;
   localparam int ME  = 5;

   // {source port, destination, length}
   localparam logic [7:0] PKT_TAB [16] = '{
      {2'd0, 3'd5, 3'd3}, {2'd1, 3'd0, 3'd2}, {2'd2, 3'd6, 3'd4}, {2'd3, 3'd1, 3'd1},
      {2'd0, 3'd7, 3'd5}, {2'd1, 3'd4, 3'd1}, {2'd2, 3'd5, 3'd2}, {2'd3, 3'd3, 3'd3},
      {2'd0, 3'd1, 3'd2}, {2'd1, 3'd2, 3'd6}, {2'd2, 3'd0, 3'd1}, {2'd3, 3'd5, 3'd4},
      {2'd0, 3'd6, 3'd7}, {2'd1, 3'd7, 3'd2}, {2'd2, 3'd4, 3'd3}, {2'd3, 3'd0, 3'd5}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DIM-1:0]    my_addr = DIM'(ME);
   logic [P-1:0]      in_valid = '0, in_head = '0, in_tail = '0;
   logic [P*DW-1:0]   in_data = '0;
   logic [P-1:0]      in_ready;
   logic [P-1:0]      out_valid, out_head, out_tail;
   logic [P-1:0]      out_ready = '0;
   logic [P*DW-1:0]   out_data;

   always #10 clk = ~clk;

   hc_router #(.DIM(DIM), .DATA_W(DW), .FIFO_DEPTH(FD)) dut_i (
      .clk(clk), .rst_n(rst_n), .my_addr(my_addr),
      .in_valid(in_valid), .in_ready(in_ready), .in_head(in_head),
      .in_tail(in_tail), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
      .out_tail(out_tail), .out_data(out_data)
   );

   int  total = 0, fails = 0;
   int  pk_src[32], pk_dest[32], pk_len[32];
   bit  pk_done[32];
   int  pkts_done = 0, flits_in = 0;
   int  rdy_mode = 0;   // 0 random, 1 all low, 2 all high
   bit  mon_en = 0;
   bit  open_p[P];
   int  cur_tag[P], fidx[P];
   int  log_tags[8];
   int  log_n = 0;
   bit  finished = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int exp_port(input int dest);
      int d, b;
      d = (dest ^ ME) & 7;
      b = 0;
      if (d == 0) return DIM;
      while ((d & 1) == 0) begin
         d = d >> 1;
         b++;
      end
      return b;
   endfunction

   task automatic set_pkt(input int t, input int s, input int d, input int l);
      pk_src[t] = s; pk_dest[t] = d; pk_len[t] = l; pk_done[t] = 0;
   endtask

   task automatic finish_pkt(input int o, input int t);
      chk(!pk_done[t], "R8", int'(pk_done[t]), 0);
      pk_done[t] = 1;
      pkts_done++;
      open_p[o] = 0;
   endtask

   task automatic handle_flit(input int o);
      logic [7:0] d;
      int t, ep;
      d = out_data[o*DW +: DW];
      if (out_head[o]) begin
         chk(!open_p[o], "R5", int'(open_p[o]), 0);
         t  = int'(d[7:3]);
         ep = exp_port(pk_dest[t]);
         chk(ep == o, (ep == DIM) ? "R3" : "R2", o, ep);
         chk(int'(d[2:0]) == pk_dest[t], "R4", int'(d[2:0]), pk_dest[t]);
         if (o == 0 && log_n < 8) begin
            log_tags[log_n] = t;
            log_n++;
         end
         cur_tag[o] = t;
         fidx[o]    = 1;
         if (out_tail[o]) begin
            chk(pk_len[t] == 1, "R4", 1, pk_len[t]);
            finish_pkt(o, t);
         end else begin
            open_p[o] = 1;
         end
      end else begin
         chk(open_p[o], "R5", int'(open_p[o]), 1);
         t = cur_tag[o];
         chk(d == {t[4:0], fidx[o][2:0]}, "R4", int'(d), (t << 3) | fidx[o]);
         chk(out_tail[o] == (fidx[o] == pk_len[t] - 1), "R4",
             int'(out_tail[o]), int'(fidx[o] == pk_len[t] - 1));
         if (out_tail[o]) finish_pkt(o, t);
         else fidx[o]++;
      end
   endtask

   // Output monitor: set ready, then take what the edge will transfer
   always @(negedge clk) begin
      if (mon_en) begin
         for (int o = 0; o < P; o++) begin
            case (rdy_mode)
               0:       out_ready[o] = (($urandom % 4) != 0);
               1:       out_ready[o] = 1'b0;
               default: out_ready[o] = 1'b1;
            endcase
         end
         for (int o = 0; o < P; o++) begin
            if (out_valid[o] && out_ready[o]) handle_flit(o);
         end
      end
   end

   function automatic int next_tag(input int p, input int from, input int last);
      for (int t = from; t <= last; t++) if (pk_src[t] == p) return t;
      return last + 1;
   endfunction

   // Drive packets first..last, each input in tag order, concurrently
   task automatic run_packets(input int first, input int last);
      int cur[P];
      int fi[P];
      bit fire[P];
      bit all_done;
      for (int p = 0; p < P; p++) begin
         cur[p] = next_tag(p, first, last);
         fi[p] = 0;
         fire[p] = 0;
      end
      forever begin
         @(negedge clk);
         all_done = 1;
         for (int p = 0; p < P; p++) begin
            if (fire[p]) begin
               flits_in++;
               fi[p]++;
               if (fi[p] == pk_len[cur[p]]) begin
                  cur[p] = next_tag(p, cur[p] + 1, last);
                  fi[p] = 0;
               end
            end
            if (cur[p] <= last) all_done = 0;
         end
         if (all_done) begin
            in_valid = '0;
            break;
         end
         for (int p = 0; p < P; p++) begin
            logic [4:0] t5;
            if (cur[p] <= last) begin
               t5 = 5'(cur[p]);
               in_valid[p] = 1'b1;
               in_head[p]  = (fi[p] == 0);
               in_tail[p]  = (fi[p] == pk_len[cur[p]] - 1);
               in_data[p*DW +: DW] = (fi[p] == 0) ? {t5, 3'(pk_dest[cur[p]])}
                                                  : {t5, 3'(fi[p])};
            end else begin
               in_valid[p] = 1'b0;
            end
            fire[p] = in_valid[p] && in_ready[p];
         end
      end
   endtask

   task automatic wait_drain(input int expect_n);
      for (int c = 0; c < 3000 && pkts_done < expect_n; c++) @(negedge clk);
      chk(pkts_done == expect_n, "R8", pkts_done, expect_n);
   endtask

   initial begin
      int start;
      logic [7:0] d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == '0, "R1", int'(out_valid), 0);
      chk(in_ready == '1, "R1", int'(in_ready), 15);
      mon_en = 1;

      // Table walk with random output readiness
      for (int t = 0; t < 16; t++)
         set_pkt(t, int'(PKT_TAB[t][7:6]), int'(PKT_TAB[t][5:3]), int'(PKT_TAB[t][2:0]));
      rdy_mode = 0;
      run_packets(0, 15);
      wait_drain(16);

      // R7: two inputs queue two packets each for port 0, then drain
      set_pkt(16, 1, 4, 2); set_pkt(17, 2, 4, 2);
      set_pkt(18, 1, 4, 2); set_pkt(19, 2, 4, 2);
      log_n = 0;
      rdy_mode = 1;
      run_packets(16, 19);
      rdy_mode = 2;
      wait_drain(20);
      chk(log_n == 4, "R7", log_n, 4);
      for (int k = 0; k < 4; k++) chk(log_tags[k] == 16 + k, "R7", log_tags[k], 16 + k);

      // R3/R4: single-flit packets, local delivery and turn-back on a link
      set_pkt(20, 0, 5, 1); set_pkt(21, 3, 5, 1); set_pkt(22, 2, 1, 1);
      rdy_mode = 0;
      run_packets(20, 22);
      wait_drain(23);

      // R6: long packet stalled on port 1 stays in place
      set_pkt(23, 3, 7, 7);
      rdy_mode = 1;
      start = flits_in;
      fork
         run_packets(23, 23);
         begin
            repeat (20) @(negedge clk);
            chk(flits_in - start == FD, "R6", flits_in - start, FD);
            chk(in_ready[3] == 1'b0, "R6", int'(in_ready[3]), 0);
            chk(out_valid[1] && out_head[1], "R6", int'(out_valid[1]), 1);
            d0 = out_data[DW +: DW];
            repeat (5) @(negedge clk);
            chk(out_valid[1] && out_data[DW +: DW] == d0, "R6",
                int'(out_data[DW +: DW]), int'(d0));
            rdy_mode = 0;
         end
      join
      wait_drain(24);

      // R8: port 1 free again for a packet from another input
      set_pkt(24, 0, 7, 2);
      run_packets(24, 24);
      wait_drain(25);

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", pkts_done, 25);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule